// File: doc/BRIEF.md
# Stop-Grant Clock Enable Controller

This block sits in the bus clock domain of a processor and turns an asynchronous, active-low stop-clock request from system logic into a sequence of clock-enable changes. When the request arrives, the controller first asks the bus interface to send a stop-grant acknowledge transaction. It waits for the bus interface to report, through a handshake input, that the acknowledge has gone out. Only then does it drop the clock enables of the core-unit domains.

The enables for the bus-interface and interrupt-controller domains are never dropped. Snooping and interrupt service therefore continue while the core units sleep, and the bus clock itself is not touched. When the request is released, the controller raises every core enable again and gives a one-cycle resume indication so that execution can restart. A request that is withdrawn before the acknowledge has been sent still lets the acknowledge complete. The controller then returns to normal running without gating anything.

Top module: `stopgrant_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, the state output reads 0 (running), every core enable is high, and ackReq and resumeExec are low.
- R2: The request passes through a two-flop synchronizer. After stopReqN falls, the state output changes from 0 to 1 (acknowledge pending) on the third rising clock edge, and ackReq is high exactly while the state is 1.
- R3: While the state is 1, ackReq stays high and every core enable stays high until ackSent is seen high on a rising edge.
- R4: If ackSent is high while the state is 1 and the synchronized request is still asserted, the state becomes 2 (stopped) on that edge, and all core enables become low on the same edge.
- R5: busClkEn and intClkEn are high in every state and at all times, including during reset.
- R6: When the synchronized request is released in state 2, the state becomes 3 (waking) with all core enables high and resumeExec high. On the next edge the state becomes 0 and resumeExec falls, so resumeExec is a single-cycle pulse.
- R7: If the request is released while the state is 1, the controller keeps ackReq high until ackSent. On that edge it goes to state 0, and the core enables never drop.
- R8: ackSent has no effect in states 0, 2 and 3. The state and the enables change only as the request dictates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset, synchronous to clk |
| stopReqN | input | 1 | Asynchronous active-low stop-clock request |
| ackSent | input | 1 | High for a cycle when the stop-grant acknowledge transaction has been sent |
| ackReq | output | 1 | Request to the bus interface to send the stop-grant acknowledge |
| coreClkEn | output | NUM_CORE | Clock enables for the core-unit domains |
| busClkEn | output | 1 | Clock enable for the bus-interface domain |
| intClkEn | output | 1 | Clock enable for the interrupt-controller domain |
| resumeExec | output | 1 | One-cycle pulse indicating that execution may resume |
| stateOut | output | 2 | Current state: 0 running, 1 acknowledge pending, 2 stopped, 3 waking |

## Verification
The assertions assume that reset is asserted from the start of time. They do not assume that ackSent is raised only in answer to ackReq: a stray ackSent in another state is legal input and must be ignored. The stimulus holds stopReqN for random stretches that may be shorter than the synchronizer latency, so request pulses can be absorbed or withdrawn during the pending state. ackSent is mostly raised while the expected state is 1, with occasional stray pulses in other states that exercise the ignore rule.

// File: rtl/stopgrant_pkg.sv
package stopgrant_pkg;
  // State codes are visible at the stateOut port
  typedef enum logic [1:0] {
    ST_RUN     = 2'd0,
    ST_ACKPEND = 2'd1,
    ST_STOPPED = 2'd2,
    ST_WAKE    = 2'd3
  } sgState_e;

  // Strobes from control to the enable datapath
  typedef struct packed {
    logic gateOff;
    logic gateOn;
  } sgStrobe_t;
endpackage

// File: rtl/sg_req_sync.sv
module sg_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqN,
  output logic reqSync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[LAST-1:0], ~reqN};
  end

  assign reqSync = chain[LAST];
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl
  import stopgrant_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stopSync,
  input  logic      ackSent,
  output sgState_e  state,
  output sgStrobe_t strb
);
  sgState_e stateNext;

  always_comb begin
    stateNext    = state;
    strb.gateOff = 1'b0;
    strb.gateOn  = 1'b0;
    unique case (state)
      ST_RUN: if (stopSync) stateNext = ST_ACKPEND;
      ST_ACKPEND: begin
        if (ackSent) begin
          if (stopSync) begin
            stateNext    = ST_STOPPED;
            strb.gateOff = 1'b1;
          end else begin
            stateNext = ST_RUN;
          end
        end
      end
      ST_STOPPED: begin
        if (!stopSync) begin
          stateNext   = ST_WAKE;
          strb.gateOn = 1'b1;
        end
      end
      ST_WAKE: stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  // R3
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKPEND && !ackSent) |=> (state == ST_ACKPEND));

  // R6
  wake_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAKE) |=> (state == ST_RUN));

  // R8
  run_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !stopSync) |=> (state == ST_RUN));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOPPED && stopSync) |=> (state == ST_STOPPED));
endmodule

// File: rtl/sg_gate_dp.sv
module sg_gate_dp
  import stopgrant_pkg::*;
#(
  parameter int NUM_CORE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  sgStrobe_t           strb,
  output logic [NUM_CORE-1:0] coreClkEn,
  output logic                busClkEn,
  output logic                intClkEn,
  output logic                resume
);
  genvar d;
  generate
    for (d = 0; d < NUM_CORE; d++) begin : g_core
      always_ff @(posedge clk) begin
        if (!rstN)             coreClkEn[d] <= 1'b1;
        else if (strb.gateOff) coreClkEn[d] <= 1'b0;
        else if (strb.gateOn)  coreClkEn[d] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) resume <= 1'b0;
    else       resume <= strb.gateOn;
  end

  // Snoop and interrupt domains are never gated
  assign busClkEn = 1'b1;
  assign intClkEn = 1'b1;

  // R6
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resume |=> !resume);

  // R4
  gate_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(coreClkEn[0]) |-> $past(strb.gateOff));
endmodule

// File: rtl/stopgrant_ctrl.sv
module stopgrant_ctrl
  import stopgrant_pkg::*;
#(
  parameter int NUM_CORE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stopReqN,
  input  logic                ackSent,
  output logic                ackReq,
  output logic [NUM_CORE-1:0] coreClkEn,
  output logic                busClkEn,
  output logic                intClkEn,
  output logic                resumeExec,
  output logic [1:0]          stateOut
);
  logic      stopSync;
  sgState_e  state;
  sgStrobe_t strb;

  sg_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .reqN(stopReqN), .reqSync(stopSync)
  );

  sg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stopSync(stopSync), .ackSent(ackSent),
    .state(state), .strb(strb)
  );

  sg_gate_dp #(.NUM_CORE(NUM_CORE)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .coreClkEn(coreClkEn),
    .busClkEn(busClkEn), .intClkEn(intClkEn), .resume(resumeExec)
  );

  assign ackReq   = (state == ST_ACKPEND);
  assign stateOut = state;

  // R4
  stopped_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOPPED) |-> (coreClkEn == '0));

  // R3
  running_ungated_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_STOPPED) |-> (&coreClkEn));

  // R6
  resume_in_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    resumeExec |-> (state == ST_WAKE));

  // R7
  withdraw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACKPEND && ackSent && !stopSync) |=> (state == ST_RUN && (&coreClkEn)));
endmodule

// File: tb/stopgrant_ctrl_tb.sv
module stopgrant_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stopReqN = 1'b1;
  logic ackSent = 1'b0;
  logic ackReq, busClkEn, intClkEn, resumeExec;
  logic [NC-1:0] coreClkEn;
  logic [1:0] stateOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit autoChk = 1'b0;

  // Reference model, in the state codes of the requirements
  logic m1 = 1'b0, m2 = 1'b0;
  logic [1:0] mState = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stopgrant_ctrl #(.NUM_CORE(NC)) u_dut (
    .clk(clk), .rstN(rstN), .stopReqN(stopReqN), .ackSent(ackSent),
    .ackReq(ackReq), .coreClkEn(coreClkEn), .busClkEn(busClkEn),
    .intClkEn(intClkEn), .resumeExec(resumeExec), .stateOut(stateOut)
  );

  function automatic logic [1:0] nextState(logic [1:0] s, logic req, logic ack);
    case (s)
      2'd0: return req ? 2'd1 : 2'd0;
      2'd1: return ack ? (req ? 2'd2 : 2'd0) : 2'd1;
      2'd2: return req ? 2'd2 : 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [NC-1:0] expCore(logic [1:0] s);
    return (s == 2'd2) ? '0 : '1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m1 <= 1'b0; m2 <= 1'b0; mState <= 2'd0;
    end else begin
      m1 <= ~stopReqN;
      m2 <= m1;
      mState <= nextState(mState, m2, ackSent);
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model
  always @(negedge clk) begin
    if (autoChk && rstN) begin
      chk(stateOut == mState, "R2", stateOut, mState);
      chk(ackReq == (mState == 2'd1), "R3", ackReq, mState == 2'd1);
      chk(coreClkEn == expCore(mState), "R4", coreClkEn, expCore(mState));
      chk(busClkEn && intClkEn, "R5", {busClkEn, intClkEn}, 3);
      chk(resumeExec == (mState == 2'd3), "R6", resumeExec, mState == 2'd3);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive(logic req, logic ack);
    #1;
    stopReqN = req;
    ackSent = ack;
  endtask

  initial begin
    #(CLK_PERIOD * 250000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) step();
    // R1 during reset
    chk(stateOut == 0 && coreClkEn == '1 && !ackReq && !resumeExec, "R1", stateOut, 0);
    chk(busClkEn && intClkEn, "R5", busClkEn, 1);
    drive(1'b1, 1'b0);
    rstN = 1'b1;
    step();
    chk(stateOut == 0 && coreClkEn == '1 && !ackReq && !resumeExec, "R1", stateOut, 0);
    autoChk = 1'b1;

    // R8: stray ack in RUN is ignored
    drive(1'b1, 1'b1); step();
    drive(1'b1, 1'b0);
    chk(stateOut == 0 && coreClkEn == '1, "R8", stateOut, 0);

    // R2: synchronizer latency of three edges
    step(); drive(1'b0, 1'b0);
    step(); chk(stateOut == 0, "R2", stateOut, 0);
    step(); chk(stateOut == 0, "R2", stateOut, 0);
    step(); chk(stateOut == 1 && ackReq, "R2", stateOut, 1);
    // R3: hold while waiting
    repeat (4) step();
    chk(ackReq && coreClkEn == '1, "R3", coreClkEn, '1);
    // R4: ack gates the core
    drive(1'b0, 1'b1); step(); drive(1'b0, 1'b0);
    chk(stateOut == 2 && coreClkEn == '0, "R4", coreClkEn, 0);
    // R8: stray ack while stopped
    drive(1'b0, 1'b1); step(); drive(1'b0, 1'b0);
    chk(stateOut == 2 && coreClkEn == '0, "R8", stateOut, 2);
    // R6: release and wake
    drive(1'b1, 1'b0);
    step(); step();
    chk(stateOut == 2, "R6", stateOut, 2);
    step();
    chk(stateOut == 3 && resumeExec && coreClkEn == '1, "R6", stateOut, 3);
    step();
    chk(stateOut == 0 && !resumeExec, "R6", stateOut, 0);

    // R7: withdraw during pending
    drive(1'b0, 1'b0);
    repeat (3) step();
    chk(stateOut == 1, "R7", stateOut, 1);
    drive(1'b1, 1'b0);
    repeat (4) step();
    chk(stateOut == 1 && ackReq, "R7", stateOut, 1);
    drive(1'b1, 1'b1); step(); drive(1'b1, 1'b0);
    chk(stateOut == 0 && coreClkEn == '1, "R7", stateOut, 0);
    repeat (2) step();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic nReq;
      logic nAck;
      step();
      nReq = stopReqN;
      if ($urandom % 12 == 0) nReq = ~stopReqN;
      nAck = 1'b0;
      if (mState == 2'd1 && ($urandom % 3 == 0)) nAck = 1'b1;
      if ($urandom % 25 == 0) nAck = 1'b1;
      drive(nReq, nAck);
    end
    step();
    autoChk = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule